// File: doc/BRIEF.md
# Memory attribute indirection decoder

This block turns a compact 3-bit attribute index, taken from a translation table entry, into a fully decoded set of memory attributes. Software programs two 32-bit attribute registers. Each register packs four 8-bit attribute bytes, so the two registers together hold eight bytes. A lookup picks one byte with the index and decodes it. The high nibble of the byte selects Device or Normal memory and gives the outer policy. The meaning of the low nibble depends on the high nibble. For Device memory it gives the ordering subtype. For Normal memory it gives the inner policy.

The write port is a valid/ready interface. A write is accepted on a rising clock edge when `wr_valid` and `wr_ready` are both high. `wr_ready` is high whenever reset is released. There is no back-pressure beyond reset: out of reset, every write offered is taken in the same cycle. The read port and the lookup path are combinational from the stored registers. An accepted write therefore shows on both paths in the cycle after the accepting edge. The registers have no reset value, so their contents are unknown until software writes them.

Top module: `attr_indirect_decoder`

## Requirements
- R1: `wr_ready` is 0 while `rst_n` is low and 1 otherwise. A write accepted at an edge shows on `rd_data` from that edge on whenever `rd_sel` equals the written `wr_sel`.
- R2: A write to one register leaves the other register's contents unchanged.
- R3: Index bit 2 selects the register: 0 selects the first register and 1 selects the second. Index bits [1:0] give the field number n, and field n is register bits [8n+7:8n].
- R4: A field whose high nibble is 0000 gives `attr_is_normal`=0 and `dev_kind` = low nibble bits [3:2]. The codes are 00 nGnRnE, 01 nGnRE, 10 nGRE and 11 GRE. In this case both policies are 00 and every hint output is 0. A Normal field gives `dev_kind`=00.
- R5: For a Device field, a low nibble whose bits [1:0] are non-zero sets `attr_bad`=1. The four legal Device codes give `attr_bad`=0.
- R6: The outer policy comes from the high nibble. The policy codes are 00 none, 01 non-cacheable, 10 write-through and 11 write-back. 0100 gives 01. 00RW or 01RW with RW not 00 gives 10 or 11 respectively, with `outer_transient`=1. 10RW gives 10 and 11RW gives 11, both with `outer_transient`=0.
- R7: For a Normal field, the low nibble gives `inner_pol` and `inner_transient` by the same scheme as R6. A low nibble of 0000 sets `attr_bad`=1, `inner_pol`=00 and every inner hint to 0. Any other low nibble gives `attr_bad`=0.
- R8: The allocate hints are read from the nibbles. `outer_ralloc` and `outer_walloc` are field bits 5 and 4. `inner_ralloc` and `inner_walloc` are field bits 1 and 0 when the field is Normal. A value of 1 means allocate. All four hints are 0 for Device.
- R9: A register does not change when `wr_valid` is low, or while reset is asserted even if `wr_valid` is high. Reset does not clear the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write can be accepted |
| wr_sel | input | 1 | Register chosen for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Register chosen for read-back |
| rd_data | output | 32 | Contents of the chosen register |
| lk_index | input | 3 | Attribute index to decode |
| attr_is_normal | output | 1 | 1 Normal memory, 0 Device memory |
| dev_kind | output | 2 | Device ordering subtype |
| outer_pol | output | 2 | Outer cache policy code |
| inner_pol | output | 2 | Inner cache policy code |
| outer_transient | output | 1 | Outer transient hint |
| inner_transient | output | 1 | Inner transient hint |
| outer_ralloc | output | 1 | Outer read-allocate hint |
| outer_walloc | output | 1 | Outer write-allocate hint |
| inner_ralloc | output | 1 | Inner read-allocate hint |
| inner_walloc | output | 1 | Inner write-allocate hint |
| attr_bad | output | 1 | Encoding is unpredictable |

## Verification
The sweep tries all 256 byte values. Each value is placed in a rotating field of a rotating register, while the rest of the bank holds the value's complement and a scrambled copy. This separates a wrong field offset from a wrong register select, and a wrong nibble split from a wrong policy table. The same lookup covers every Device code, legal and illegal, and every Normal outer/inner pairing, including the zero inner nibble. Directed write sequences then tell apart cross-register corruption, writes taken without `wr_valid`, and writes taken during reset.

// File: rtl/attr_pkg.sv
package attr_pkg;
  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_NC   = 2'b01,
    POL_WT   = 2'b10,
    POL_WB   = 2'b11
  } cache_pol_e;

  typedef struct packed {
    cache_pol_e pol;
    logic       transient;
    logic       ralloc;
    logic       walloc;
    logic       zero;
  } level_attr_t;
endpackage

// File: rtl/attr_regbank.sv
module attr_regbank #(
  parameter int NUM_REGS = 2,
  parameter int REG_W    = 32,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [SEL_W-1:0]          rd_sel,
  output logic [REG_W-1:0]          rd_data,
  output logic [NUM_REGS*REG_W-1:0] bank_flat
);
  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // No reset: contents stay unknown until software writes them.
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == SEL_W'(g))) begin
        regs[g] <= wr_data;
      end
    end
    assign bank_flat[g*REG_W +: REG_W] = regs[g];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (rd_sel == SEL_W'(k)) rd_data = regs[k];
    end
  end
endmodule

// File: rtl/attr_field_pick.sv
module attr_field_pick #(
  parameter int NUM_REGS  = 2,
  parameter int REG_W     = 32,
  parameter int FIELD_W   = 8,
  localparam int NUM_FLD  = NUM_REGS * (REG_W / FIELD_W),
  localparam int IDX_W    = $clog2(NUM_FLD)
) (
  input  logic [NUM_REGS*REG_W-1:0] bank_flat,
  input  logic [IDX_W-1:0]          index,
  output logic [FIELD_W-1:0]        field
);
  // Register r sits at bank bits [r*REG_W +: REG_W] and field n at [n*FIELD_W]
  // inside it, so the flat field number equals {register, field} = index.
  logic [FIELD_W-1:0] fields [NUM_FLD];

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    assign fields[f] = bank_flat[f*FIELD_W +: FIELD_W];
  end

  always_comb begin
    field = '0;
    for (int k = 0; k < NUM_FLD; k++) begin
      if (index == IDX_W'(k)) field = fields[k];
    end
  end
endmodule

// File: rtl/attr_nibble_decode.sv
module attr_nibble_decode
  import attr_pkg::*;
(
  input  logic [3:0]  nib,
  output level_attr_t lvl
);
  always_comb begin
    lvl           = '0;
    lvl.pol       = POL_NONE;
    lvl.zero      = (nib == 4'b0000);
    if (nib == 4'b0100) begin
      lvl.pol = POL_NC;
    end else if (nib != 4'b0000) begin
      // bit 2 picks write-back over write-through; bit 3 clear means transient
      lvl.pol       = nib[2] ? POL_WB : POL_WT;
      lvl.transient = ~nib[3];
      lvl.ralloc    = nib[1];
      lvl.walloc    = nib[0];
    end
  end
endmodule

// File: rtl/attr_indirect_decoder.sv
module attr_indirect_decoder
  import attr_pkg::*;
#(
  parameter int NUM_REGS  = 2,
  parameter int REG_W     = 32,
  parameter int FIELD_W   = 8,
  localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int IDX_W    = $clog2(NUM_REGS * (REG_W / FIELD_W))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [REG_W-1:0]   rd_data,
  input  logic [IDX_W-1:0]   lk_index,
  output logic               attr_is_normal,
  output logic [1:0]         dev_kind,
  output logic [1:0]         outer_pol,
  output logic [1:0]         inner_pol,
  output logic               outer_transient,
  output logic               inner_transient,
  output logic               outer_ralloc,
  output logic               outer_walloc,
  output logic               inner_ralloc,
  output logic               inner_walloc,
  output logic               attr_bad
);
  localparam int HALF_W = FIELD_W / 2;

  logic [NUM_REGS*REG_W-1:0] bank_flat;
  logic [FIELD_W-1:0]        field;
  level_attr_t               outer_lvl;
  level_attr_t               inner_lvl;
  logic                      normal;

  assign wr_ready = rst_n;

  attr_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
    .clk      (clk),
    .wr_en    (wr_valid && wr_ready),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .bank_flat(bank_flat)
  );

  attr_field_pick #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .FIELD_W(FIELD_W)) u_pick (
    .bank_flat(bank_flat),
    .index    (lk_index),
    .field    (field)
  );

  attr_nibble_decode u_outer (.nib(field[FIELD_W-1 -: 4]), .lvl(outer_lvl));
  attr_nibble_decode u_inner (.nib(field[HALF_W-1 -: 4]),  .lvl(inner_lvl));

  always_comb begin
    normal          = ~outer_lvl.zero;
    attr_is_normal  = normal;
    dev_kind        = normal ? 2'b00 : field[3:2];
    outer_pol       = outer_lvl.pol;
    outer_transient = outer_lvl.transient;
    outer_ralloc    = outer_lvl.ralloc;
    outer_walloc    = outer_lvl.walloc;
    inner_pol       = normal ? inner_lvl.pol : POL_NONE;
    inner_transient = normal & inner_lvl.transient;
    inner_ralloc    = normal & inner_lvl.ralloc;
    inner_walloc    = normal & inner_lvl.walloc;
    attr_bad        = normal ? inner_lvl.zero : (field[1:0] != 2'b00);
  end
endmodule

// File: rtl/attr_decode_checker.sv
module attr_decode_checker #(
  parameter int SEL_W = 1,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [SEL_W-1:0] wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic [SEL_W-1:0] rd_sel,
  input logic [REG_W-1:0] rd_data,
  input logic             attr_is_normal,
  input logic [1:0]       dev_kind,
  input logic [1:0]       outer_pol,
  input logic [1:0]       inner_pol,
  input logic             outer_transient,
  input logic             inner_transient,
  input logic             outer_ralloc,
  input logic             outer_walloc,
  input logic             inner_ralloc,
  input logic             inner_walloc,
  input logic             attr_bad
);
  always @(posedge clk) begin
    if (!rst_n) a_r1_no_ready_in_reset : assert (!wr_ready);
  end

  a_r1_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> ((rd_sel != $past(wr_sel)) || (rd_data == $past(wr_data))));

  a_r9_hold_without_write : assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> (!$stable(rd_sel) || $stable(rd_data)));

  a_r4_device_no_hints : assert property (@(posedge clk) disable iff (!rst_n)
    !attr_is_normal |-> (outer_pol == 2'b00 && inner_pol == 2'b00 && !outer_transient &&
                         !inner_transient && !outer_ralloc && !outer_walloc &&
                         !inner_ralloc && !inner_walloc));

  a_r6_normal_has_outer : assert property (@(posedge clk) disable iff (!rst_n)
    attr_is_normal |-> (outer_pol != 2'b00 && dev_kind == 2'b00));

  a_r7_bad_inner_empty : assert property (@(posedge clk) disable iff (!rst_n)
    (attr_is_normal && attr_bad) |-> (inner_pol == 2'b00 && !inner_ralloc && !inner_walloc &&
                                     !inner_transient));

  a_r8_nc_no_alloc : assert property (@(posedge clk) disable iff (!rst_n)
    (outer_pol == 2'b01) |-> (!outer_ralloc && !outer_walloc && !outer_transient));
endmodule

bind attr_indirect_decoder attr_decode_checker #(.SEL_W(SEL_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
  .attr_is_normal(attr_is_normal), .dev_kind(dev_kind), .outer_pol(outer_pol),
  .inner_pol(inner_pol), .outer_transient(outer_transient),
  .inner_transient(inner_transient), .outer_ralloc(outer_ralloc),
  .outer_walloc(outer_walloc), .inner_ralloc(inner_ralloc),
  .inner_walloc(inner_walloc), .attr_bad(attr_bad)
);

// File: tb/attr_indirect_decoder_tb_top.sv
module attr_indirect_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, wr_valid, wr_ready, wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic [2:0]  lk_index;
  logic        attr_is_normal, outer_transient, inner_transient;
  logic [1:0]  dev_kind, outer_pol, inner_pol;
  logic        outer_ralloc, outer_walloc, inner_ralloc, inner_walloc, attr_bad;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_indirect_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .lk_index(lk_index), .attr_is_normal(attr_is_normal), .dev_kind(dev_kind),
    .outer_pol(outer_pol), .inner_pol(inner_pol), .outer_transient(outer_transient),
    .inner_transient(inner_transient), .outer_ralloc(outer_ralloc),
    .outer_walloc(outer_walloc), .inner_ralloc(inner_ralloc),
    .inner_walloc(inner_walloc), .attr_bad(attr_bad)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {policy[1:0], transient, ralloc, walloc} for one nibble, per R6/R8
  function automatic logic [4:0] lvl_model(logic [3:0] n);
    if (n == 4'd0)      return 5'b0;
    if (n == 4'b0100)   return {2'b01, 3'b000};
    return {(n[2] ? 2'b11 : 2'b10), ~n[3], n[1], n[0]};
  endfunction

  task automatic wr(logic s, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic s, logic [31:0] exp);
    rd_sel = s; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic field_chk(logic [2:0] idx, logic [7:0] v);
    logic       normal;
    logic [4:0] o, i;
    lk_index = idx; #1;
    normal = (v[7:4] != 4'd0);
    o = lvl_model(v[7:4]);
    i = normal ? lvl_model(v[3:0]) : 5'b0;
    chk("R3/R4 normal flag", attr_is_normal, normal);
    chk("R4 dev_kind", dev_kind, normal ? 2'b00 : v[3:2]);
    chk("R6 outer policy", {outer_pol, outer_transient}, o[4:2]);
    chk("R7 inner policy", {inner_pol, inner_transient}, i[4:2]);
    chk("R8 alloc hints", {outer_ralloc, outer_walloc, inner_ralloc, inner_walloc},
        {o[1:0], i[1:0]});
    if (normal) chk("R7 bad", attr_bad, v[3:0] == 4'd0);
    else        chk("R5 bad", attr_bad, v[1:0] != 2'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_sel = 1'b0; wr_data = '0;
    rd_sel = 1'b0; lk_index = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", wr_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", wr_ready, 1'b1);

    // Both registers written before any lookup (contents unknown until then).
    wr(1'b0, 32'hA1B2_C3D4);
    wr(1'b1, 32'h1122_3344);
    rd_chk("R1 reg0 readback", 1'b0, 32'hA1B2_C3D4);
    rd_chk("R1 reg1 readback", 1'b1, 32'h1122_3344);
    wr(1'b1, 32'h5566_7788);
    rd_chk("R2 reg0 untouched", 1'b0, 32'hA1B2_C3D4);
    rd_chk("R2 reg1 updated", 1'b1, 32'h5566_7788);
    wr(1'b0, 32'h0F0F_F0F0);
    rd_chk("R2 reg1 untouched", 1'b1, 32'h5566_7788);

    // R9: data presented without wr_valid
    @(negedge clk);
    wr_sel = 1'b0; wr_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rd_chk("R9 no valid no write", 1'b0, 32'h0F0F_F0F0);

    // R9: write attempted while in reset
    rst_n = 1'b0;
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 1'b0; wr_data = 32'hCAFE_F00D;
    #1 chk("R1 ready low in second reset", wr_ready, 1'b0);
    @(negedge clk);
    wr_valid = 1'b0;
    rst_n = 1'b1;
    rd_chk("R9 reset blocks write", 1'b0, 32'h0F0F_F0F0);
    rd_chk("R9 reset keeps reg1", 1'b1, 32'h5566_7788);

    // Sweep every byte value across rotating field positions (R3..R8).
    for (int v = 0; v < 256; v++) begin
      logic [7:0]  b, other;
      logic [2:0]  p;
      logic [31:0] w, w2;
      b = 8'(v); p = 3'(v % 8); other = b ^ 8'h5A;
      w = {4{~b}};
      w[p[1:0]*8 +: 8] = b;
      w2 = {4{other}};
      wr(p[2], w);
      wr(~p[2], w2);
      rd_chk("R3 target reg", p[2], w);
      rd_chk("R3 other reg", ~p[2], w2);
      field_chk(p, b);
      field_chk(p ^ 3'b100, other);
      field_chk(p ^ 3'b001, ~b);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule